// File: doc/BRIEF.md
# One-Time Fuse Program and Protection Controller

This block owns a bank of one-time-programmable bits modelled as flops. A bit in the bank can go from 0 to 1 but never back. The bank is split into 32-bit words, and each word belongs to one protection group. Word 0 is the control word, and its fields govern the rest of the bank:

- Bits 15:0 hold the write-disable field.
- Bits 19:16 hold the read-disable field.
- Bits 21:20 hold the stored coding-scheme selector.
- Bit 22 holds the reserve flag.

Words 1 to 3 carry general parameters. Words 4 to 11, 12 to 19 and 20 to 27 are three key blocks, each 256 bits wide.

Software controls the block over a single-cycle register bus. It fills a program-data image at addresses 0x00 to 0x1B, one register per fuse word. It writes the unlock value 0x5A5A to the key register at 0x3C. It then writes 0x2 to the command register at 0x3D. The controller then runs for `PROG_CYCLES` cycles and ORs every permitted image bit into the bank. The command register reads 0x2 while the controller is busy and 0x0 afterwards. A level interrupt rises when the operation finishes; software clears it by writing 1 to bit 0 of the interrupt register at 0x3E. Software reads the bank at 0x20 plus the word index, and that view is gated by the read-disable field. Hardware consumers always see the whole bank on a separate output.

Top module: `efc_top`

## Requirements
- R1: After each program operation, every bank word equals its previous value ORed with the permitted image bits. No bank bit ever returns from 1 to 0.
- R2: Write-disable bits are assigned per word: words 0 to 3 use bits 0 to 3, key block 1 uses bit 7, key block 2 uses bit 8, and key block 3 uses bit 9. While the assigned bit is 1, a program operation leaves that word unchanged.
- R3: Word 0 is covered by write-disable bit 0. Once that bit is set, word 0 never changes again, so every protection bit already set stays set.
- R4: The write-disable field and the reserve flag are sampled from the bank when a command is accepted. A protection bit programmed by an operation affects only later operations.
- R5: Read-disable bits are assigned as follows: bit 0 covers key block 1, bit 1 covers key block 2, bit 2 covers key block 3, and bit 3 covers word 3. A bus read of a covered word returns zero while its bit is 1. Uncovered words stay readable, and `fuse_bits_o` always shows the true contents.
- R6: A command is accepted only when the value is 0x2, the key register holds 0x5A5A and no operation is busy. Every write to the command register clears the key, so a command without a fresh key write has no effect on the bank or the interrupt.
- R7: After an accepted command, the command register reads 0x2 for exactly `PROG_CYCLES` cycles and then reads 0x0. The interrupt rises in the same cycle that the register returns to 0x0.
- R8: The interrupt, readable at bit 0 of 0x3E, stays high until 1 is written to bit 0 of 0x3E. Writing 0 there leaves it high.
- R9: While the reserve flag (word 0 bit 22) is set, words 24 and 25 are never programmed; these are encoded bits 191:128 of key block 3. In that state `coding_o` reads 2'b01 whatever the stored selector is. Otherwise `coding_o` equals word 0 bits 21:20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 7 | Register address for both writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Level program-done interrupt |
| fuse_bits_o | output | 896 | Full bank contents for hardware consumers, word w at bits [32w+31:32w] |
| coding_o | output | 2 | Effective key-block coding scheme |

## Verification
The bank is the only long-lived state, so a corrupted protection mask or a wrong commit shows up at the first read after the operation that caused it. It can show on `fuse_bits_o` or through the gated bus view: a word holds extra bits, lacks permitted bits, or returns a value where zero was due. Sequencing faults show within one operation. These include a command taken without a key, a busy window of the wrong length, or an interrupt that drops by itself, and they appear as a wrong count of busy reads or as the interrupt level at completion. The scenarios deliberately set protection bits in the same operation that programs the words they guard, because a mask sampled at the wrong time is otherwise invisible.

// File: rtl/efc_pkg.sv
package efc_pkg;
  localparam int DW          = 32;
  localparam int SYS_WORDS   = 4;
  localparam int KEY_WORDS   = 8;
  localparam int KEY_BLOCKS  = 3;
  localparam int NW          = SYS_WORDS + KEY_BLOCKS * KEY_WORDS;
  localparam int IW          = $clog2(NW);
  localparam int AW          = 7;

  localparam logic [AW-1:0] A_FUSE = 7'h20;
  localparam logic [AW-1:0] A_KEY  = 7'h3C;
  localparam logic [AW-1:0] A_CMD  = 7'h3D;
  localparam logic [AW-1:0] A_INT  = 7'h3E;

  localparam logic [15:0]   UNLOCK   = 16'h5A5A;
  localparam logic [DW-1:0] CMD_PROG = 32'h2;

  // control word layout
  localparam int WD_LSB  = 0;
  localparam int WD_BITS = 16;
  localparam int RD_LSB  = 16;
  localparam int RD_BITS = 4;
  localparam int CS_LSB  = 20;
  localparam int RSV_BIT = 22;

  // words of key block 3 held back by the reserve flag
  localparam int RSV_LO  = SYS_WORDS + 2 * KEY_WORDS + 4;
  localparam int RSV_CNT = 2;

  function automatic int wd_index(int w);
    if (w < SYS_WORDS) return w;
    return 7 + (w - SYS_WORDS) / KEY_WORDS;
  endfunction

  // -1 means the word is always readable
  function automatic int rd_index(int w);
    if (w == SYS_WORDS - 1) return 3;
    if (w < SYS_WORDS) return -1;
    return (w - SYS_WORDS) / KEY_WORDS;
  endfunction

  function automatic bit reserved_word(int w);
    return (w >= RSV_LO) && (w < RSV_LO + RSV_CNT);
  endfunction
endpackage

// File: rtl/efc_regs.sv
module efc_regs
  import efc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             prog_busy_i,
  output logic [NW*DW-1:0] pgm_o,
  output logic             start_o,
  output logic             irq_clr_o
);
  logic [DW-1:0] pgm_q [NW];
  logic [NW-1:0] pgm_we;
  logic [15:0]   key_q, key_d;
  logic          key_en;
  logic          cmd_wr;

  assign cmd_wr = bus_we && (bus_addr == A_CMD);

  for (genvar w = 0; w < NW; w++) begin : g_img
    assign pgm_we[w] = bus_we && (bus_addr == AW'(w));
    assign pgm_o[w*DW +: DW] = pgm_q[w];
  end

  always_comb begin
    key_en = 1'b0;
    key_d  = key_q;
    if (cmd_wr) begin
      key_en = 1'b1;
      key_d  = '0;
    end else if (bus_we && (bus_addr == A_KEY)) begin
      key_en = 1'b1;
      key_d  = bus_wdata[15:0];
    end
  end

  assign start_o   = cmd_wr && (bus_wdata == CMD_PROG) && (key_q == UNLOCK) && !prog_busy_i;
  assign irq_clr_o = bus_we && (bus_addr == A_INT) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      for (int w = 0; w < NW; w++) pgm_q[w] <= '0;
    end else begin
      if (key_en) key_q <= key_d;
      for (int w = 0; w < NW; w++) begin
        if (pgm_we[w]) pgm_q[w] <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/efc_seq.sv
module efc_seq #(
  parameter int PROG_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic irq_clr_i,
  output logic busy_o,
  output logic done_o,
  output logic irq_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          irq_q, irq_d;

  assign done_o = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CW'(PROG_CYCLES - 1);
    end else if (done_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (done_o)         irq_d = 1'b1;
    else if (irq_clr_i) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      irq_q  <= irq_d;
    end
  end

  assign busy_o = busy_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/efc_array.sv
module efc_array
  import efc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [NW*DW-1:0] pgm_i,
  input  logic [IW-1:0]    rsel_i,
  output logic [NW*DW-1:0] fuse_o,
  output logic [DW-1:0]    rdata_o,
  output logic [1:0]       coding_o
);
  logic [DW-1:0]      fuse_q [NW];
  logic [DW-1:0]      fuse_d [NW];
  logic [DW-1:0]      vis    [NW];
  logic [NW-1:0]      fuse_en;
  logic [WD_BITS-1:0] wd_q, wd_d;
  logic               rsv_q, rsv_d;
  logic [RD_BITS-1:0] rd_dis;

  assign rd_dis = fuse_q[0][RD_LSB +: RD_BITS];

  // masks frozen at command acceptance
  always_comb begin
    wd_d  = wd_q;
    rsv_d = rsv_q;
    if (start_i) begin
      wd_d  = fuse_q[0][WD_LSB +: WD_BITS];
      rsv_d = fuse_q[0][RSV_BIT];
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam int WDI = wd_index(w);
    localparam int RDI = rd_index(w);
    logic lock;
    if (reserved_word(w)) begin : g_rsv
      assign lock = wd_q[WDI] | rsv_q;
    end else begin : g_open
      assign lock = wd_q[WDI];
    end
    assign fuse_en[w] = done_i && !lock;
    assign fuse_d[w]  = fuse_q[w] | pgm_i[w*DW +: DW];
    assign fuse_o[w*DW +: DW] = fuse_q[w];
    if (RDI < 0) begin : g_pub
      assign vis[w] = fuse_q[w];
    end else begin : g_gate
      assign vis[w] = rd_dis[RDI] ? '0 : fuse_q[w];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NW; w++) begin
      if (rsel_i == IW'(w)) rdata_o = vis[w];
    end
  end

  assign coding_o = fuse_q[0][RSV_BIT] ? 2'b01 : fuse_q[0][CS_LSB +: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q  <= '0;
      rsv_q <= 1'b0;
      for (int w = 0; w < NW; w++) fuse_q[w] <= '0;
    end else begin
      wd_q  <= wd_d;
      rsv_q <= rsv_d;
      for (int w = 0; w < NW; w++) begin
        if (fuse_en[w]) fuse_q[w] <= fuse_d[w];
      end
    end
  end
endmodule

// File: rtl/efc_top.sv
module efc_top
  import efc_pkg::*;
#(
  parameter int PROG_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [6:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_o,
  output logic [895:0]     fuse_bits_o,
  output logic [1:0]       coding_o
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [NW*DW-1:0] pgm;
  logic             start, done, prog_busy, irq_clr;
  logic [DW-1:0]    fuse_rd;
  logic [IW-1:0]    rsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign rsel = bus_addr[IW-1:0];

  efc_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .prog_busy_i(prog_busy), .pgm_o(pgm),
    .start_o(start), .irq_clr_o(irq_clr)
  );

  efc_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start), .irq_clr_i(irq_clr),
    .busy_o(prog_busy), .done_o(done), .irq_o(irq_o)
  );

  efc_array u_array (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start), .done_i(done),
    .pgm_i(pgm), .rsel_i(rsel), .fuse_o(fuse_bits_o), .rdata_o(fuse_rd),
    .coding_o(coding_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < AW'(NW))
      bus_rdata = pgm[rsel*DW +: DW];
    else if ((bus_addr >= A_FUSE) && (bus_addr < A_FUSE + AW'(NW)))
      bus_rdata = fuse_rd;
    else if (bus_addr == A_CMD)
      bus_rdata = prog_busy ? CMD_PROG : '0;
    else if (bus_addr == A_INT)
      bus_rdata = {{(DW-1){1'b0}}, irq_o};
  end
endmodule

// File: rtl/efc_chk.sv
module efc_chk
  import efc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic             irq_o,
  input logic             prog_busy,
  input logic [NW*DW-1:0] fuse_bits_o
);
  AST_FUSE_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(fuse_bits_o) & ~fuse_bits_o) == '0)); // R1

  AST_WD_SELF_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_bits_o[WD_LSB] |=> $stable(fuse_bits_o[DW-1:0])); // R3

  AST_RD_GATE_KEY1: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_bits_o[RD_LSB] && (bus_addr == A_FUSE + AW'(SYS_WORDS))) |-> (bus_rdata == '0)); // R5

  AST_IRQ_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(prog_busy) && !prog_busy)); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(bus_we && (bus_addr == A_INT) && bus_wdata[0])) |=> irq_o); // R8

  AST_RSV_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_bits_o[RSV_BIT] |=> $stable(fuse_bits_o[RSV_LO*DW +: RSV_CNT*DW])); // R9
endmodule

bind efc_top efc_chk chk_i (
  .clk(clk), .rst_n(rst_sync_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .prog_busy(prog_busy), .fuse_bits_o(fuse_bits_o)
);

// File: tb/efc_top_tb_top.sv
`timescale 1ns/1ps
module efc_top_tb_top;
  localparam int PC = 8;
  localparam int NWB = 28;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_we;
  logic [6:0]   bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic         irq_o;
  logic [895:0] fuse_bits_o;
  logic [1:0]   coding_o;

  efc_top #(.PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .fuse_bits_o(fuse_bits_o), .coding_o(coding_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] fz [NWB];
  logic [31:0] pg [NWB];

  // scoreboard
  logic [31:0] exp_q [$];
  logic [31:0] act_q [$];
  string       tag_q [$];
  event        ev_chk;

  function automatic void drain();
    while (act_q.size() > 0) begin
      logic [31:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  endfunction

  initial forever begin
    @(ev_chk);
    drain();
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    tag_q.push_back(t);
    exp_q.push_back(exp);
    act_q.push_back(act);
    -> ev_chk;
  endtask

  task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_pg(input int w, input logic [31:0] v);
    bus_wr(7'(w), v);
    pg[w] = v;
  endtask

  function automatic int wd_of(int w);
    if (w < 4) return w;
    return 7 + (w - 4) / 8;
  endfunction

  function automatic bit visible(int w);
    logic [3:0] rdb;
    rdb = fz[0][19:16];
    if (w == 3) return !rdb[3];
    if (w < 4) return 1'b1;
    return !rdb[(w - 4) / 8];
  endfunction

  // full program operation with mirror update, returns busy read count
  task automatic prog_op(output int busy_cnt);
    logic [15:0] wd;
    logic        rsv;
    logic [31:0] r;
    wd  = fz[0][15:0];
    rsv = fz[0][22];
    bus_wr(7'h3C, 32'h5A5A);
    bus_wr(7'h3D, 32'h2);
    busy_cnt = 0;
    for (int i = 0; i < 200; i++) begin
      bus_rd(7'h3D, r);
      if (r != 32'h2) break;
      busy_cnt++;
      @(negedge clk);
    end
    for (int w = 0; w < NWB; w++) begin
      if (!wd[wd_of(w)] && !(rsv && (w == 24 || w == 25))) fz[w] = fz[w] | pg[w];
    end
  endtask

  task automatic check_all(input string t);
    logic [31:0] r;
    for (int w = 0; w < NWB; w++) begin
      bus_rd(7'h20 + 7'(w), r);
      check($sformatf("%s bus word %0d", t, w), r, visible(w) ? fz[w] : 32'h0);
      check($sformatf("%s hw word %0d", t, w), fuse_bits_o[w*32 +: 32], fz[w]);
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    for (int w = 0; w < NWB; w++) begin fz[w] = '0; pg[w] = '0; end
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    check_all("reset");
    bus_rd(7'h3D, r); check("reset cmd idle", r, 32'h0);
    check("reset irq", {31'b0, irq_o}, 32'h0);
    check("reset coding", {30'b0, coding_o}, 32'h0);

    // R6: commands without a valid fresh key
    set_pg(1, 32'h0000_00A5);
    set_pg(3, 32'h0000_0077);
    bus_wr(7'h3D, 32'h2);
    repeat (PC + 4) @(negedge clk);
    check("R6 no key word1", fuse_bits_o[32 +: 32], 32'h0);
    check("R6 no key irq", {31'b0, irq_o}, 32'h0);
    bus_wr(7'h3C, 32'h1234);
    bus_wr(7'h3D, 32'h2);
    repeat (PC + 4) @(negedge clk);
    check("R6 wrong key word1", fuse_bits_o[32 +: 32], 32'h0);
    bus_wr(7'h3C, 32'h5A5A);
    bus_wr(7'h3D, 32'h3);
    bus_wr(7'h3D, 32'h2);
    repeat (PC + 4) @(negedge clk);
    bus_rd(7'h3D, r); check("R6 consumed key cmd", r, 32'h0);
    check("R6 consumed key word1", fuse_bits_o[32 +: 32], 32'h0);
    check("R6 consumed key irq", {31'b0, irq_o}, 32'h0);

    // R7: busy window and interrupt at finish
    prog_op(n);
    check("R7 busy cycles", 32'(n), 32'(PC));
    check("R7 irq at finish", {31'b0, irq_o}, 32'h1);
    check_all("R1 first program");

    // R8: level interrupt, clear by writing 1
    repeat (5) @(negedge clk);
    check("R8 irq held", {31'b0, irq_o}, 32'h1);
    bus_wr(7'h3E, 32'h0);
    check("R8 zero write keeps irq", {31'b0, irq_o}, 32'h1);
    bus_rd(7'h3E, r); check("R8 irq readback", r, 32'h1);
    bus_wr(7'h3E, 32'h1);
    check("R8 irq cleared", {31'b0, irq_o}, 32'h0);

    // R1: OR-only accumulation
    set_pg(1, 32'h0000_0F00);
    prog_op(n);
    check_all("R1 accumulate");
    set_pg(1, 32'h0);
    prog_op(n);
    check("R1 zero image keeps word1", fuse_bits_o[32 +: 32], 32'h0000_0FA5);

    // R4: protection set in the same operation does not apply yet
    set_pg(0, 32'h0000_0002);
    set_pg(1, 32'hFFFF_0000);
    prog_op(n);
    check("R4 word1 still written", fuse_bits_o[32 +: 32], 32'hFFFF_0FA5);
    check_all("R4 same op");

    // R2: protection applies to later operations
    set_pg(1, 32'hFFFF_FFFF);
    set_pg(2, 32'h0000_003C);
    prog_op(n);
    check("R2 word1 locked", fuse_bits_o[32 +: 32], 32'hFFFF_0FA5);
    check("R2 word2 open", fuse_bits_o[64 +: 32], 32'h0000_003C);
    check_all("R2 later op");

    // R5: read protection on key block 1
    set_pg(4, 32'hDEAD_BEEF);
    set_pg(8, 32'h1234_5678);
    prog_op(n);
    check_all("R5 before read protect");
    set_pg(0, 32'h0001_0002);
    prog_op(n);
    bus_rd(7'h24, r); check("R5 key1 hidden", r, 32'h0);
    check("R5 key1 hw view", fuse_bits_o[4*32 +: 32], 32'hDEAD_BEEF);
    bus_rd(7'h23, r); check("R5 word3 readable", r, 32'h0000_0077);
    check_all("R5 after read protect");

    // R9: reserve flag
    set_pg(0, 32'h0041_0002);
    prog_op(n);
    check("R9 coding forced", {30'b0, coding_o}, 32'h1);
    set_pg(23, 32'h11);
    set_pg(24, 32'h22);
    set_pg(25, 32'h33);
    set_pg(26, 32'h44);
    prog_op(n);
    check("R9 word24 held", fuse_bits_o[24*32 +: 32], 32'h0);
    check("R9 word25 held", fuse_bits_o[25*32 +: 32], 32'h0);
    check("R9 word23 written", fuse_bits_o[23*32 +: 32], 32'h11);
    check_all("R9 reserve");

    // R3: self-protection of the control word
    set_pg(0, 32'h0041_0003);
    prog_op(n);
    check("R3 lock bit set", fuse_bits_o[31:0], 32'h0041_0003);
    set_pg(0, 32'h0063_0023);
    set_pg(2, 32'h0000_0100);
    prog_op(n);
    check("R3 control word frozen", fuse_bits_o[31:0], 32'h0041_0003);
    check_all("R3 after lock");

    #1;
    drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule